// File: doc/BRIEF.md
# Eight-Input Interrupt Priority Controller

This block collects eight level-sensitive interrupt request lines and decides which of them, if any, should interrupt the processor. It keeps three 8-bit registers: sampled requests, mask bits and in-service bits. It raises one interrupt output when an unmasked request outranks everything already in service. When the processor pulses its acknowledge input, the block puts an 8-bit type number on the read data bus. In the same cycle it marks the winner as in service and clears the winner's request bit.

Priority is held as a pointer to the lowest-priority input. In fixed mode the pointer stays at input 7, so input 0 ranks highest. In rotating mode, end-of-interrupt commands that carry the rotate flag move the pointer to the input that was just released, so that input drops to the bottom of the order. Software reaches the block through chip select, read and write strobes, one address bit and an 8-bit write data bus.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Among the unmasked pending requests, the winner is the first one found when walking upward from the input just above the lowest-priority pointer, wrapping past 7 to 0. After reset and after every init the pointer is 7, so input 0 ranks highest and input 7 lowest.
- R2: The type number driven on `rdata` while `ack` is high is {base[4:0], winner index[2:0]}. The base is loaded from `wdata[7:3]` by the first write to address 1 that follows an init write.
- R3: A write to address 1 that does not follow an init loads the mask register. A mask bit of 1 stops that input from ever raising `irq_out`, whatever its request line does.
- R4: `irq_out` is high only when the winning request ranks strictly above every input whose in-service bit is set. A request of equal or lower rank waits until those bits are cleared.
- R5: On a cycle with `ack` high and a forwarded request, `irq_out` is low, the winner's in-service bit is set, and the winner's request bit is cleared.
- R6: A command byte with `wdata[7:5]`=001 (nonspecific end of interrupt) clears the highest-ranked in-service bit.
- R7: A command byte with `wdata[7:5]`=011 (specific end of interrupt) clears the in-service bit named by `wdata[2:0]` and leaves the other in-service bits unchanged.
- R8: A command byte with `wdata[7:5]`=101 clears the highest-ranked in-service bit. In rotating mode that input then becomes the lowest priority. In fixed mode the command acts as a plain nonspecific end of interrupt.
- R9: A command byte with `wdata[7:5]`=111 clears the in-service bit named by `wdata[2:0]`. In rotating mode the named input becomes the lowest priority.
- R10: A write to address 0 with `wdata[4]`=1 is an init. It selects rotating mode when `wdata[0]`=1, clears the mask and in-service registers, resets the pointer to 7 and arms the base load. A write to address 0 with `wdata[4]`=0 is a command byte.
- R11: A read with `sel` and `rd` returns the in-service register at address 0 and the mask register at address 1. While `ack` is high, `rdata` carries the type number instead.
- R12: An `ack` with no forwarded request returns {base, 3'b111} and changes no in-service bit.
- R13: After reset, `irq_out` is low, mask and in-service are zero, base is zero, and the mode is fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 8 | Level-sensitive request lines, one per input |
| sel | input | 1 | Chip select for register access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 1 | Register location select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, or the type number during acknowledge |
| ack | input | 1 | Interrupt acknowledge from the processor |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The vector table drives the priority pick with several request and mask pairs. Two simultaneous requests show that lower indices win in fixed order. A mask over the winner shows that the next input takes over. A fully masked set and an empty set show that nothing is forwarded, and a lone request on input 7 checks the index at the wrap boundary.

Directed sequences then cover the remaining behaviour. Nesting is tried with a higher request arriving while a lower one is in service, which separates strict outranking from plain pending. Two inputs held high through repeated rotate commands show the order flipping, and the same commands in fixed mode show that no rotation happens. A specific end of interrupt against two in-service bits shows that only the named one is cleared.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // Decoded action of a single register-port cycle
   typedef struct packed {
      logic init;      // mode/init write on location 0
      logic rot_en;    // rotating mode requested by init
      logic base_ld;   // location 1 write right after init
      logic mask_ld;   // ordinary location 1 write
      logic eoi;       // any end-of-interrupt command
      logic eoi_spec;  // command names its input
      logic eoi_rot;   // command carries the rotate flag
   } pic_cmd_t;

   localparam int unsigned CMD_INIT_BIT = 4;
   localparam int unsigned CMD_ROT_BIT  = 0;

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
   import prio_irq_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned IW = 3
) (
   input  logic          sel,
   input  logic          wr,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   input  logic          base_armed,
   output pic_cmd_t      cmd,
   output logic [IW-1:0] level
);

   logic wr_hit;
   logic [2:0] op;

   initial begin
      assert (DW >= 8 && IW < DW) else $error("pic_cmd_decode: bad widths");
   end

   assign wr_hit = sel & wr;
   assign op     = wdata[7:5];
   assign level  = wdata[IW-1:0];

   always_comb begin
      cmd          = '0;
      cmd.init     = wr_hit & ~addr & wdata[CMD_INIT_BIT];
      cmd.rot_en   = wdata[CMD_ROT_BIT];
      cmd.base_ld  = wr_hit & addr & base_armed;
      cmd.mask_ld  = wr_hit & addr & ~base_armed;
      cmd.eoi      = wr_hit & ~addr & ~wdata[CMD_INIT_BIT] & op[0];
      cmd.eoi_spec = op[1];
      cmd.eoi_rot  = op[2];
   end

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   input  logic [IW-1:0] lowest,
   output logic          found,
   output logic [IW-1:0] idx
);

   logic [N-1:0] rot;

   initial begin
      assert (N == (1 << IW)) else $error("pic_prio_pick: N must be a power of two");
   end

   // rot[0] is the input ranked highest, rot[N-1] the lowest
   for (genvar k = 0; k < N; k++) begin : g_rot
      assign rot[k] = vec[IW'(lowest + IW'(k + 1))];
   end

   always_comb begin
      found = 1'b0;
      idx   = lowest;
      for (int k = N - 1; k >= 0; k--) begin
         if (rot[k]) begin
            found = 1'b1;
            idx   = IW'(lowest + IW'(k + 1));
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 8,
   parameter int unsigned DW      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               sel,
   input  logic               rd,
   input  logic               wr,
   input  logic               addr,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      rdata,
   input  logic               ack,
   output logic               irq_out
);

   localparam int unsigned IW = $clog2(NUM_IRQ);
   localparam int unsigned BW = DW - IW;

   initial begin
      assert (NUM_IRQ == DW && NUM_IRQ == (1 << IW))
         else $error("prio_irq_ctrl: NUM_IRQ must equal DW and be a power of two");
   end

   logic [NUM_IRQ-1:0] irr_q, mask_q, isr_q;
   logic [IW-1:0]      lowp_q;
   logic [BW-1:0]      base_q;
   logic               rot_mode_q, armed_q;

   pic_cmd_t      cmd;
   logic [IW-1:0] cmd_level;

   logic               req_found, isr_found, fwd;
   logic [IW-1:0]      req_idx, isr_idx;
   logic [NUM_IRQ-1:0] isr_set, isr_clr, pend;

   pic_cmd_decode #(.DW(DW), .IW(IW)) u_dec (
      .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
      .base_armed(armed_q), .cmd(cmd), .level(cmd_level)
   );

   assign pend = irr_q & ~mask_q;

   pic_prio_pick #(.N(NUM_IRQ), .IW(IW)) u_req_pick (
      .vec(pend), .lowest(lowp_q), .found(req_found), .idx(req_idx)
   );

   pic_prio_pick #(.N(NUM_IRQ), .IW(IW)) u_isr_pick (
      .vec(isr_q), .lowest(lowp_q), .found(isr_found), .idx(isr_idx)
   );

   // Rank 0 is the highest priority under the current pointer
   function automatic logic [IW-1:0] rank_of(input logic [IW-1:0] i,
                                             input logic [IW-1:0] lp);
      return IW'(i - lp - IW'(1));
   endfunction

   assign fwd = req_found &
                (~isr_found | (rank_of(req_idx, lowp_q) < rank_of(isr_idx, lowp_q)));

   assign irq_out = fwd & ~ack;

   always_comb begin
      isr_set = '0;
      isr_clr = '0;
      if (ack && fwd) isr_set[req_idx] = 1'b1;
      if (cmd.eoi) begin
         if (cmd.eoi_spec)    isr_clr[cmd_level] = 1'b1;
         else if (isr_found)  isr_clr[isr_idx]   = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q      <= '0;
         mask_q     <= '0;
         isr_q      <= '0;
         lowp_q     <= '1;
         base_q     <= '0;
         rot_mode_q <= 1'b0;
         armed_q    <= 1'b0;
      end else begin
         irr_q <= irq_req & ~isr_set;
         if (cmd.init) begin
            mask_q     <= '0;
            isr_q      <= '0;
            lowp_q     <= '1;
            rot_mode_q <= cmd.rot_en;
            armed_q    <= 1'b1;
         end else begin
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (cmd.base_ld) begin
               base_q  <= wdata[DW-1:IW];
               armed_q <= 1'b0;
            end
            if (cmd.mask_ld) mask_q <= wdata[NUM_IRQ-1:0];
            if (cmd.eoi && cmd.eoi_rot && rot_mode_q) begin
               if (cmd.eoi_spec)   lowp_q <= cmd_level;
               else if (isr_found) lowp_q <= isr_idx;
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (ack)             rdata = {base_q, (fwd ? req_idx : {IW{1'b1}})};
      else if (sel && rd)  rdata = addr ? DW'(mask_q) : DW'(isr_q);
   end

   // R3
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((irr_q & ~mask_q) != '0));

   // R4
   nest_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> !isr_q[req_idx]);

   // R5
   ack_isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && fwd && !cmd.init) |=> isr_q[$past(req_idx)]);

   // R5
   ack_irr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && fwd) |=> !irr_q[$past(req_idx)]);

   // R6
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.eoi && !cmd.eoi_spec && isr_found && !ack) |=> !isr_q[$past(isr_idx)]);

   // R8
   rot_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.eoi && cmd.eoi_rot && !cmd.eoi_spec && rot_mode_q && isr_found)
      |=> (lowp_q == $past(isr_idx)));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req = '0;
   logic       sel = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0, ack = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_out;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sel(sel), .rd(rd),
      .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack),
      .irq_out(irq_out)
   );

   // {mask, req, expected irq, expected type number}, base 0xA0
   localparam logic [24:0] VECS [6] = '{
      {8'h00, 8'h50, 1'b1, 8'hA4},
      {8'h10, 8'h50, 1'b1, 8'hA6},
      {8'hFF, 8'hFF, 1'b0, 8'h00},
      {8'h00, 8'h80, 1'b1, 8'hA7},
      {8'hFE, 8'h03, 1'b1, 8'hA0},
      {8'h00, 8'h00, 1'b0, 8'h00}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h, expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic reg_rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; rd = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      sel = 1'b0; rd = 1'b0;
   endtask

   task automatic do_ack(input string req, input logic [7:0] exp);
      @(negedge clk);
      ack = 1'b1;
      #1;
      check(req, rdata, exp);
      check("R5 irq low during ack", {7'd0, irq_out}, 8'h00);
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic set_req(input logic [7:0] r);
      @(negedge clk);
      irq_req = r;
      @(negedge clk);
      #1;
   endtask

   task automatic init(input logic rot, input logic [7:0] base);
      reg_wr(1'b0, {7'b0001000, rot});
      reg_wr(1'b1, base);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R13 reset state
      #1 check("R13 irq after reset", {7'd0, irq_out}, 8'h00);
      reg_rd(1'b1, d); check("R13 mask after reset", d, 8'h00);
      reg_rd(1'b0, d); check("R13 isr after reset", d, 8'h00);
      do_ack("R13 base zero spurious", 8'h07);

      // Vector table: R1 R2 R3
      for (int i = 0; i < 6; i++) begin
         set_req(8'h00);
         init(1'b0, 8'hA0);
         reg_wr(1'b1, VECS[i][24:17]);
         set_req(VECS[i][16:9]);
         check("R3 R1 irq from table", {7'd0, irq_out}, {7'd0, VECS[i][8]});
         if (VECS[i][8]) begin
            do_ack("R2 R1 type number from table", VECS[i][7:0]);
            set_req(8'h00);
            reg_wr(1'b0, 8'h20);
         end
      end

      // R11 mask readback
      reg_wr(1'b1, 8'h5A);
      reg_rd(1'b1, d); check("R11 mask readback", d, 8'h5A);

      // R10 init clears mask
      init(1'b0, 8'hA0);
      reg_rd(1'b1, d); check("R10 init clears mask", d, 8'h00);

      // R4 nesting
      set_req(8'h50);
      do_ack("R4 first of IR4/IR6", 8'hA4);
      #1 check("R4 IR6 blocked by IR4", {7'd0, irq_out}, 8'h00);
      set_req(8'h54);
      check("R4 IR2 outranks IR4", {7'd0, irq_out}, 8'h01);
      do_ack("R4 IR2 vector", 8'hA2);
      reg_rd(1'b0, d); check("R5 isr holds IR2 and IR4", d, 8'h14);
      set_req(8'h50);
      reg_wr(1'b0, 8'h20);
      reg_rd(1'b0, d); check("R6 nonspecific clears IR2", d, 8'h10);
      #1 check("R4 IR6 still blocked", {7'd0, irq_out}, 8'h00);
      reg_wr(1'b0, 8'h20);
      #1 check("R6 IR4 released", {7'd0, irq_out}, 8'h01);
      set_req(8'h40);
      do_ack("R4 IR6 after IR4", 8'hA6);
      reg_wr(1'b0, 8'h20);
      set_req(8'h00);

      // R7 specific EOI
      set_req(8'h10);
      do_ack("R7 setup IR4", 8'hA4);
      set_req(8'h14);
      do_ack("R7 setup IR2", 8'hA2);
      reg_wr(1'b0, 8'h64);
      reg_rd(1'b0, d); check("R7 specific clears only IR4", d, 8'h04);
      reg_wr(1'b0, 8'h20);
      reg_rd(1'b0, d); check("R6 isr empty", d, 8'h00);
      set_req(8'h00);

      // R8 fixed mode: rotate flag does not rotate
      set_req(8'h50);
      do_ack("R8 fixed first", 8'hA4);
      reg_wr(1'b0, 8'hA0);
      do_ack("R8 fixed no rotation", 8'hA4);
      reg_wr(1'b0, 8'h20);
      set_req(8'h00);

      // R8 rotating mode
      init(1'b1, 8'hA0);
      set_req(8'h50);
      do_ack("R8 rotate first", 8'hA4);
      reg_wr(1'b0, 8'hA0);
      do_ack("R8 IR4 dropped to lowest", 8'hA6);
      reg_wr(1'b0, 8'hA0);
      do_ack("R8 IR6 dropped to lowest", 8'hA4);
      reg_rd(1'b0, d); check("R11 isr readback", d, 8'h10);

      // R9 rotate on specific
      reg_wr(1'b0, 8'hE4);
      reg_rd(1'b0, d); check("R9 named bit cleared", d, 8'h00);
      set_req(8'h28);
      do_ack("R9 IR5 outranks IR3", 8'hA5);
      reg_wr(1'b0, 8'h25);
      set_req(8'h00);

      // R12 spurious acknowledge
      init(1'b0, 8'hA0);
      do_ack("R12 spurious vector", 8'hA7);
      reg_rd(1'b0, d); check("R12 isr unchanged", d, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule